// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of token latches that two independent requesters, called the left and the right port, use to agree on who may touch a shared resource. Each token is always in one of three ownership states: free, held by the left port, or held by the right port. A port can also have a request outstanding against a token that the other port holds. Software on either side claims a token by writing a request and gives it back by writing a release. It then reads the token to learn whether the claim succeeded.

Each port has a semaphore strobe, a token index, a write enable, a one-bit write value and a registered one-bit read value. A write value of 0 requests a token and a write value of 1 releases it. A read returns 0 when the reading port owns the token and 1 otherwise. A request made while the other side holds the token is kept pending. The token then passes to the requester, with no further access, in the cycle the holder releases it. Each port also has a memory chip-enable input, so that a semaphore access that collides with a memory access on the same port can be dropped.

Top module: `sem_bank_unit`

## Requirements
- R1: After a synchronous active-high reset every token is free and both read values are 1.
- R2: A read (strobe 1, chip enable 0, write enable 0) returns 0 on the read value one clock later if the reading port owns the indexed token and 1 otherwise. Reads change no token state. The read value holds between reads and during writes.
- R3: A request (write value 0) to a free token makes the requesting port its owner.
- R4: A request to a token held by the other port leaves the holder in place and records the request as pending. When the holder releases the token, the requester becomes the owner in that same update.
- R5: A release (write value 1) by the owner with no pending request makes the token free, so that it reads 1 on both ports.
- R6: If both ports request the same free token in the same cycle, the left port becomes owner and the right request becomes pending.
- R7: Releases are applied before requests within one cycle. A holder's release and the other port's request to the same token in the same cycle give the token to the requester.
- R8: A release by a port that neither owns nor has a pending request for the token has no effect.
- R9: A release by a port whose request is pending withdraws that request. The holder keeps the token, and a later release by the holder frees it.
- R10: An access with the strobe and the chip enable both 1 on one port is ignored. It changes no token and leaves that port's read value unchanged.
- R11: Tokens are independent. An access to one index never changes the state of another.
- R12: At no time do both ports own the same token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sem_sel | input | 1 | Left semaphore strobe |
| l_ram_ce | input | 1 | Left memory chip enable (a collision with the strobe drops the access) |
| l_tok_idx | input | IDX_W | Left token index |
| l_wr_en | input | 1 | Left write enable |
| l_wr_val | input | 1 | Left write value: 0 request, 1 release |
| l_rd_val | output | 1 | Left registered read value: 0 owned, 1 not owned |
| r_sem_sel | input | 1 | Right semaphore strobe |
| r_ram_ce | input | 1 | Right memory chip enable |
| r_tok_idx | input | IDX_W | Right token index |
| r_wr_en | input | 1 | Right write enable |
| r_wr_val | input | 1 | Right write value: 0 request, 1 release |
| r_rd_val | output | 1 | Right registered read value |

## Verification
The bench builds the block with the default of eight tokens, so the 3-bit index covers every token and the top index, 7, is used directly. The directed sequences cover the following cases:
- both ports on the same index in the same cycle;
- a release and a request colliding;
- withdrawal of a pending request;
- accesses dropped because of the chip enable.

A long random phase then keeps the two ports on overlapping indices, so that the left-priority and hand-over paths are hit many times.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    TK_FREE  = 2'd0,
    TK_LEFT  = 2'd1,
    TK_RIGHT = 2'd2
  } tok_owner_e;

  typedef struct packed {
    tok_owner_e owner;
    logic       pend_l;
    logic       pend_r;
  } tok_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
  input  logic               sem_sel,
  input  logic               ram_ce,
  input  logic [IDX_W-1:0]   tok_idx,
  input  logic               wr_en,
  input  logic               wr_val,
  output logic               rd_en,
  output logic [NUM_TOK-1:0] req_vec,
  output logic [NUM_TOK-1:0] rel_vec
);
  logic acc_ok;
  assign acc_ok = sem_sel & ~ram_ce;
  assign rd_en  = acc_ok & ~wr_en;

  for (genvar g = 0; g < NUM_TOK; g++) begin : g_dec
    logic hit;
    assign hit        = acc_ok & wr_en & (tok_idx == IDX_W'(g));
    assign req_vec[g] = hit & ~wr_val;
    assign rel_vec[g] = hit &  wr_val;
  end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r
);
  tok_state_t cur, nxt;

  always_comb begin
    nxt = cur;
    // withdrawals of pending requests
    if (rel_l && cur.pend_l) nxt.pend_l = 1'b0;
    if (rel_r && cur.pend_r) nxt.pend_r = 1'b0;
    // releases by the holder, with hand-over to a waiting requester
    if (rel_l && cur.owner == TK_LEFT) begin
      if (nxt.pend_r) begin
        nxt.owner  = TK_RIGHT;
        nxt.pend_r = 1'b0;
      end else begin
        nxt.owner = TK_FREE;
      end
    end
    if (rel_r && cur.owner == TK_RIGHT) begin
      if (nxt.pend_l) begin
        nxt.owner  = TK_LEFT;
        nxt.pend_l = 1'b0;
      end else begin
        nxt.owner = TK_FREE;
      end
    end
    // requests, left first
    if (req_l) begin
      if (nxt.owner == TK_FREE)       nxt.owner  = TK_LEFT;
      else if (nxt.owner == TK_RIGHT) nxt.pend_l = 1'b1;
    end
    if (req_r) begin
      if (nxt.owner == TK_FREE)      nxt.owner  = TK_RIGHT;
      else if (nxt.owner == TK_LEFT) nxt.pend_r = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.owner  <= TK_FREE;
      cur.pend_l <= 1'b0;
      cur.pend_r <= 1'b0;
    end else begin
      cur <= nxt;
    end
  end

  assign own_l = (cur.owner == TK_LEFT);
  assign own_r = (cur.owner == TK_RIGHT);
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   tok_idx,
  input  logic [NUM_TOK-1:0] own_vec,
  output logic               rd_val
);
  always_ff @(posedge clk) begin
    if (rst)        rd_val <= 1'b1;
    else if (rd_en) rd_val <= ~own_vec[tok_idx];
  end
endmodule

// File: rtl/sem_bank_unit.sv
module sem_bank_unit #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l_sem_sel,
  input  logic             l_ram_ce,
  input  logic [IDX_W-1:0] l_tok_idx,
  input  logic             l_wr_en,
  input  logic             l_wr_val,
  output logic             l_rd_val,
  input  logic             r_sem_sel,
  input  logic             r_ram_ce,
  input  logic [IDX_W-1:0] r_tok_idx,
  input  logic             r_wr_en,
  input  logic             r_wr_val,
  output logic             r_rd_val
);
  logic               l_rd_en, r_rd_en;
  logic [NUM_TOK-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_TOK-1:0] l_own, r_own;

  sem_port_decode #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_l (
    .sem_sel(l_sem_sel), .ram_ce(l_ram_ce), .tok_idx(l_tok_idx),
    .wr_en(l_wr_en), .wr_val(l_wr_val),
    .rd_en(l_rd_en), .req_vec(l_req), .rel_vec(l_rel)
  );

  sem_port_decode #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_r (
    .sem_sel(r_sem_sel), .ram_ce(r_ram_ce), .tok_idx(r_tok_idx),
    .wr_en(r_wr_en), .wr_val(r_wr_val),
    .rd_en(r_rd_en), .req_vec(r_req), .rel_vec(r_rel)
  );

  for (genvar g = 0; g < NUM_TOK; g++) begin : g_tok
    sem_token_cell u_cell (
      .clk(clk), .rst(rst),
      .req_l(l_req[g]), .rel_l(l_rel[g]),
      .req_r(r_req[g]), .rel_r(r_rel[g]),
      .own_l(l_own[g]), .own_r(r_own[g])
    );
  end

  sem_read_port #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_rd_l (
    .clk(clk), .rst(rst), .rd_en(l_rd_en), .tok_idx(l_tok_idx),
    .own_vec(l_own), .rd_val(l_rd_val)
  );

  sem_read_port #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_rd_r (
    .clk(clk), .rst(rst), .rd_en(r_rd_en), .tok_idx(r_tok_idx),
    .own_vec(r_own), .rd_val(r_rd_val)
  );
endmodule

// File: rtl/sem_bank_checker.sv
module sem_bank_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             l_sem_sel,
  input logic             l_ram_ce,
  input logic [IDX_W-1:0] l_tok_idx,
  input logic             l_wr_en,
  input logic             l_rd_val,
  input logic             r_sem_sel,
  input logic             r_ram_ce,
  input logic [IDX_W-1:0] r_tok_idx,
  input logic             r_wr_en,
  input logic             r_rd_val
);
  // R1: reset drives both read values to 1
  a_r1_reset_free: assert property (@(posedge clk)
    rst |=> (l_rd_val && r_rd_val));

  // R10: collision with the chip enable leaves the read value alone
  a_r10_l_collision: assert property (@(posedge clk) disable iff (rst)
    (l_sem_sel && l_ram_ce) |=> $stable(l_rd_val));
  a_r10_r_collision: assert property (@(posedge clk) disable iff (rst)
    (r_sem_sel && r_ram_ce) |=> $stable(r_rd_val));

  // R2: writes do not disturb the read value
  a_r2_l_write_hold: assert property (@(posedge clk) disable iff (rst)
    (l_sem_sel && !l_ram_ce && l_wr_en) |=> $stable(l_rd_val));
  a_r2_r_write_hold: assert property (@(posedge clk) disable iff (rst)
    (r_sem_sel && !r_ram_ce && r_wr_en) |=> $stable(r_rd_val));

  // R12: two simultaneous reads of one token never both report ownership
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    (l_sem_sel && !l_ram_ce && !l_wr_en &&
     r_sem_sel && !r_ram_ce && !r_wr_en && (l_tok_idx == r_tok_idx))
    |=> (l_rd_val || r_rd_val));
endmodule

bind sem_bank_unit sem_bank_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_sem_sel(l_sem_sel), .l_ram_ce(l_ram_ce), .l_tok_idx(l_tok_idx),
  .l_wr_en(l_wr_en), .l_rd_val(l_rd_val),
  .r_sem_sel(r_sem_sel), .r_ram_ce(r_ram_ce), .r_tok_idx(r_tok_idx),
  .r_wr_en(r_wr_en), .r_rd_val(r_rd_val)
);

// File: tb/sem_bank_unit_tb_top.sv
module sem_bank_unit_tb_top;
  localparam int NT = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_sel = 0, l_ce = 0, l_we = 0, l_wv = 0;
  logic r_sel = 0, r_ce = 0, r_we = 0, r_wv = 0;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic l_rd, r_rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model: 0 free, 1 left, 2 right
  int own[NT];
  bit pl[NT], pr[NT];
  bit exp_l = 1, exp_r = 1;

  always #10 clk = ~clk;

  sem_bank_unit #(.NUM_TOK(NT)) dut_i (
    .clk(clk), .rst(rst),
    .l_sem_sel(l_sel), .l_ram_ce(l_ce), .l_tok_idx(l_idx),
    .l_wr_en(l_we), .l_wr_val(l_wv), .l_rd_val(l_rd),
    .r_sem_sel(r_sel), .r_ram_ce(r_ce), .r_tok_idx(r_idx),
    .r_wr_en(r_we), .r_wr_val(r_wv), .r_rd_val(r_rd)
  );

  task automatic check(string tag, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit la, ra;
    int li, ri;
    la = l_sel && !l_ce;
    ra = r_sel && !r_ce;
    li = int'(l_idx);
    ri = int'(r_idx);
    if (la && !l_we) exp_l = (own[li] == 1) ? 1'b0 : 1'b1;
    if (ra && !r_we) exp_r = (own[ri] == 2) ? 1'b0 : 1'b1;
    if (la && l_we && l_wv && pl[li]) pl[li] = 0;
    if (ra && r_we && r_wv && pr[ri]) pr[ri] = 0;
    if (la && l_we && l_wv && own[li] == 1) begin
      if (pr[li]) begin own[li] = 2; pr[li] = 0; end
      else own[li] = 0;
    end
    if (ra && r_we && r_wv && own[ri] == 2) begin
      if (pl[ri]) begin own[ri] = 1; pl[ri] = 0; end
      else own[ri] = 0;
    end
    if (la && l_we && !l_wv) begin
      if (own[li] == 0) own[li] = 1;
      else if (own[li] == 2) pl[li] = 1;
    end
    if (ra && r_we && !r_wv) begin
      if (own[ri] == 0) own[ri] = 2;
      else if (own[ri] == 1) pr[ri] = 1;
    end
  endtask

  // one clock: drive, advance model, compare both read values
  task automatic cyc(string tag,
                     bit ls, bit lc, int li, bit lw, bit lv,
                     bit rs, bit rc, int ri, bit rw, bit rv);
    l_sel = ls; l_ce = lc; l_idx = IW'(li); l_we = lw; l_wv = lv;
    r_sel = rs; r_ce = rc; r_idx = IW'(ri); r_we = rw; r_wv = rv;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag, "left read", l_rd, exp_l);
    check(tag, "right read", r_rd, exp_r);
  endtask

  task automatic l_op(string tag, int i, bit we, bit v);
    cyc(tag, 1, 0, i, we, v, 0, 0, 0, 0, 0);
  endtask
  task automatic r_op(string tag, int i, bit we, bit v);
    cyc(tag, 0, 0, 0, 0, 0, 1, 0, i, we, v);
  endtask
  task automatic both_rd(string tag, int i);
    cyc(tag, 1, 0, i, 0, 0, 1, 0, i, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) begin own[i] = 0; pl[i] = 0; pr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1", "left after reset", l_rd, 1'b1);
    check("R1", "right after reset", r_rd, 1'b1);
    for (int i = 0; i < NT; i++) both_rd("R1", i);

    // R3 / R2: grant on free token, reads report ownership
    l_op("R3", 3, 1, 0);
    both_rd("R3", 3);
    both_rd("R2", 3);            // repeated read leaves state alone
    // R4: pending request granted on release
    r_op("R4", 3, 1, 0);
    both_rd("R4", 3);
    l_op("R4", 3, 1, 1);
    both_rd("R4", 3);
    // R5: release with nobody waiting
    r_op("R5", 3, 1, 1);
    both_rd("R5", 3);
    // R8: release of an unowned token
    r_op("R8", 5, 1, 1);
    both_rd("R8", 5);
    l_op("R8", 5, 1, 0);
    r_op("R8", 5, 1, 1);
    both_rd("R8", 5);
    l_op("R8", 5, 1, 1);
    // R6: simultaneous request, left wins
    cyc("R6", 1, 0, 6, 1, 0, 1, 0, 6, 1, 0);
    both_rd("R6", 6);
    l_op("R6", 6, 1, 1);
    both_rd("R6", 6);
    // R9: withdrawal of pending request
    l_op("R9", 6, 1, 0);
    l_op("R9", 6, 1, 1);
    r_op("R9", 6, 1, 1);
    both_rd("R9", 6);
    // R10: access dropped on chip-enable collision
    cyc("R10", 1, 1, 2, 1, 0, 0, 0, 0, 0, 0);
    both_rd("R10", 2);
    l_op("R10", 4, 1, 0);
    l_op("R10", 4, 0, 0);        // left read value now 0
    cyc("R10", 1, 1, 2, 0, 0, 1, 1, 4, 1, 0);
    both_rd("R10", 4);
    l_op("R10", 4, 1, 1);
    // R11: independent tokens
    cyc("R11", 1, 0, 0, 1, 0, 1, 0, 7, 1, 0);
    l_op("R11", 0, 0, 0);
    r_op("R11", 7, 0, 0);
    both_rd("R11", 1);
    both_rd("R11", 6);
    l_op("R11", 0, 1, 1);
    r_op("R11", 7, 1, 1);
    // R7: release and request on same token in one cycle
    l_op("R7", 1, 1, 0);
    cyc("R7", 1, 0, 1, 1, 1, 1, 0, 1, 1, 0);
    both_rd("R7", 1);
    r_op("R7", 1, 1, 1);
    // R12: random traffic on overlapping indices
    for (int k = 0; k < 4000; k++) begin
      cyc("R12",
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0),
          $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0),
          $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < NT; i++) both_rd("R12", i);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule